// File: doc/BRIEF.md
# Seven-to-one LVDS pixel serializer

This block turns a stream of 18-bit RGB pixels, each with its horizontal sync, vertical sync and data-enable flags, into four serial data lanes and one clock lane for a flat-panel link. It runs entirely on the bit clock, which is seven times the pixel rate. An internal slot counter raises `in_ready` for one bit-clock cycle in every seven. A pixel is taken on that edge and loaded into five seven-bit shift registers, one per lane, which then shift one slot per cycle, slot 1 first. The clock lane is loaded on the same strobe with a fixed pattern, so the clock lane and the data lanes stay aligned by construction.

Two configuration pins shape the data lanes. `cfg_map_sel` chooses between an LSB-first map (0) and an MSB-first map (1). `cfg_slot_swap` exchanges adjacent slot pairs on every data lane. Both pins are sampled only at the load strobe. The input side is a valid/ready stream with no stall capability, since the link can never pause. The source must present its pixel while `in_ready` is high. A pixel is taken only when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` never depends on `in_valid`. If no pixel is offered at a strobe, the block sends a blanking word. A source that cannot keep up with one pixel per seven bit clocks therefore produces blank periods, not back-pressure.

Top module: `lvds_pix_serializer`

## Requirements
- R1: `in_ready` is high in exactly one bit-clock cycle out of every seven. A pixel is accepted only at a rising edge where `in_valid` and `in_ready` are both high.
- R2: Slot 1 of the word loaded at an accepting edge appears on the lane outputs in the cycle after that edge. Slots 2 to 7 follow on the next six cycles, one slot per cycle.
- R3: The clock lane carries 1,1,0,0,0,1,1 in slots 1 to 7 of every word.
- R4: With `cfg_map_sel`=0, the 21 payload bits R0..R5, G0..G5, B0..B5, HS, VS, DE fill lane 0 slots 1-7, then lane 1 slots 1-7, then lane 2 slots 1-7, in that order.
- R5: With `cfg_map_sel`=1, the payload order is R5..R0, G5..G0, B5..B0, HS, VS, DE, using the same lane and slot filling as R4.
- R6: In both maps, HS, VS and DE occupy slots 5, 6 and 7 of lane 2.
- R7: Lane 3 is always 0.
- R8: With `cfg_slot_swap`=1, each data lane exchanges slots 1↔2, 3↔4 and 5↔6. Slot 7 and the clock lane are unchanged.
- R9: `cfg_map_sel` and `cfg_slot_swap` take effect only at a load edge. A change between strobes does not alter a word already being shifted.
- R10: If `in_valid` is low at a load edge, a blank word is sent. Its colour bits and DE are 0, and HS and VS repeat the values of the last accepted pixel (0 after reset).
- R11: While `rst_n` is low, all lane outputs are 0. `in_ready` is high in the first cycle after `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Load strobe; pixel taken when valid and ready are both high |
| in_red | input | 6 | Red component |
| in_grn | input | 6 | Green component |
| in_blu | input | 6 | Blue component |
| in_hsync | input | 1 | Horizontal sync |
| in_vsync | input | 1 | Vertical sync |
| in_de | input | 1 | Data enable |
| cfg_map_sel | input | 1 | 0 = LSB-first map, 1 = MSB-first map |
| cfg_slot_swap | input | 1 | 1 = exchange adjacent slot pairs on data lanes |
| lane_d_o | output | 4 | Serial data lanes 3..0 |
| lane_clk_o | output | 1 | Serial clock lane |

## Verification
If the slot counter drifts or skips a state, the clock-lane pattern shifts against `in_ready` within one seven-cycle pixel period. The deserializing reference model then flags every following slot. A mapping or swap fault shows up in the first word loaded under the affected mode, at the exact slot where the bit is misplaced. A wrong sync hold register only shows after an accepted pixel is followed by a strobe with no valid. For that reason, the bench mixes gaps into the stream and toggles the configuration pins between strobes.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int CH_W_DEF      = 6;  // bits per colour channel
  localparam int SLOTS_DEF     = 7;  // serial slots per pixel period
  localparam int DLANES_DEF    = 4;  // data lanes
  localparam int SYNC_LANE_DEF = 2;  // lane holding HS/VS/DE
endpackage

// File: rtl/lvds_lane_map.sv
module lvds_lane_map #(
  parameter int CH_W   = 6,
  parameter int SLOTS  = 7,
  parameter int DLANES = 4
) (
  input  logic [CH_W-1:0]               red_i,
  input  logic [CH_W-1:0]               grn_i,
  input  logic [CH_W-1:0]               blu_i,
  input  logic                          hs_i,
  input  logic                          vs_i,
  input  logic                          de_i,
  input  logic                          msb_first_i,
  output logic [DLANES-1:0][SLOTS-1:0]  words_o
);
  localparam int NBITS = 3*CH_W + 3;

  logic [NBITS-1:0] seq;

  // payload in transmit order; colour bit order depends on the map
  always_comb begin
    for (int i = 0; i < CH_W; i++) begin
      seq[i]          = msb_first_i ? red_i[CH_W-1-i] : red_i[i];
      seq[CH_W+i]     = msb_first_i ? grn_i[CH_W-1-i] : grn_i[i];
      seq[2*CH_W+i]   = msb_first_i ? blu_i[CH_W-1-i] : blu_i[i];
    end
    seq[3*CH_W]   = hs_i;
    seq[3*CH_W+1] = vs_i;
    seq[3*CH_W+2] = de_i;
  end

  // fill lanes slot by slot; unused positions are zero
  always_comb begin
    for (int l = 0; l < DLANES; l++) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (l*SLOTS + s < NBITS) words_o[l][s] = seq[l*SLOTS + s];
        else                     words_o[l][s] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/lvds_slot_swap.sv
module lvds_slot_swap #(
  parameter int SLOTS  = 7,
  parameter int DLANES = 4
) (
  input  logic                          swap_i,
  input  logic [DLANES-1:0][SLOTS-1:0]  words_i,
  output logic [DLANES-1:0][SLOTS-1:0]  words_o
);
  for (genvar l = 0; l < DLANES; l++) begin : g_lane
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      // partner slot; an unpaired last slot keeps its place
      localparam int PARTNER = ((s ^ 1) < SLOTS) ? (s ^ 1) : s;
      assign words_o[l][s] = swap_i ? words_i[l][PARTNER] : words_i[l][s];
    end
  end
endmodule

// File: rtl/lvds_shift_lane.sv
module lvds_shift_lane #(
  parameter int SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SLOTS-1:0] par_i,
  output logic             ser_o
);
  logic [SLOTS-1:0] sh_q;

  // index 0 is the slot on the wire; shift toward it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh_q <= '0;
    else if (load_i) sh_q <= par_i;
    else             sh_q <= {1'b0, sh_q[SLOTS-1:1]};
  end

  assign ser_o = sh_q[0];
endmodule

// File: rtl/lvds_pix_serializer.sv
module lvds_pix_serializer
  import lvds_ser_pkg::*;
#(
  parameter int CH_W      = CH_W_DEF,
  parameter int SLOTS     = SLOTS_DEF,
  parameter int DLANES    = DLANES_DEF,
  parameter int SYNC_LANE = SYNC_LANE_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CH_W-1:0]   in_red,
  input  logic [CH_W-1:0]   in_grn,
  input  logic [CH_W-1:0]   in_blu,
  input  logic              in_hsync,
  input  logic              in_vsync,
  input  logic              in_de,
  input  logic              cfg_map_sel,
  input  logic              cfg_slot_swap,
  output logic [DLANES-1:0] lane_d_o,
  output logic              lane_clk_o
);
  localparam int CW      = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int HI_CNT  = (SLOTS + 1) / 2;
  localparam int HI_HEAD = HI_CNT / 2;
  localparam int HI_TAIL = HI_CNT - HI_HEAD;
  localparam logic [CW-1:0] LAST_SLOT = CW'(SLOTS - 1);

  function automatic logic [SLOTS-1:0] clk_pattern();
    logic [SLOTS-1:0] p;
    for (int s = 0; s < SLOTS; s++)
      p[s] = (s < HI_HEAD) || (s >= SLOTS - HI_TAIL);
    return p;
  endfunction

  localparam logic [SLOTS-1:0] CLK_PAT = clk_pattern();

  logic [CW-1:0] slot_q;
  logic          take;
  logic          hs_hold_q, vs_hold_q;
  logic [CH_W-1:0] red_w, grn_w, blu_w;
  logic          hs_w, vs_w, de_w;
  logic [DLANES-1:0][SLOTS-1:0] mapped_w, swapped_w;

  // slot counter: strobe on the last slot, first strobe right after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                slot_q <= LAST_SLOT;
    else if (slot_q == LAST_SLOT) slot_q <= '0;
    else                       slot_q <= slot_q + 1'b1;
  end

  assign in_ready = (slot_q == LAST_SLOT);
  assign take     = in_valid & in_ready;

  // sync levels persist through blank words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_hold_q <= 1'b0;
      vs_hold_q <= 1'b0;
    end else if (take) begin
      hs_hold_q <= in_hsync;
      vs_hold_q <= in_vsync;
    end
  end

  always_comb begin
    red_w = take ? in_red : '0;
    grn_w = take ? in_grn : '0;
    blu_w = take ? in_blu : '0;
    hs_w  = take ? in_hsync : hs_hold_q;
    vs_w  = take ? in_vsync : vs_hold_q;
    de_w  = take & in_de;
  end

  lvds_lane_map #(.CH_W(CH_W), .SLOTS(SLOTS), .DLANES(DLANES)) u_map (
    .red_i(red_w), .grn_i(grn_w), .blu_i(blu_w),
    .hs_i(hs_w), .vs_i(vs_w), .de_i(de_w),
    .msb_first_i(cfg_map_sel),
    .words_o(mapped_w)
  );

  lvds_slot_swap #(.SLOTS(SLOTS), .DLANES(DLANES)) u_swap (
    .swap_i(cfg_slot_swap),
    .words_i(mapped_w),
    .words_o(swapped_w)
  );

  for (genvar l = 0; l < DLANES; l++) begin : g_data
    lvds_shift_lane #(.SLOTS(SLOTS)) u_sh (
      .clk(clk), .rst_n(rst_n), .load_i(in_ready),
      .par_i(swapped_w[l]), .ser_o(lane_d_o[l])
    );
  end

  lvds_shift_lane #(.SLOTS(SLOTS)) u_clk_sh (
    .clk(clk), .rst_n(rst_n), .load_i(in_ready),
    .par_i(CLK_PAT), .ser_o(lane_clk_o)
  );
endmodule

// File: rtl/lvds_ser_chk.sv
module lvds_ser_chk #(
  parameter int DLANES    = 4,
  parameter int SYNC_LANE = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_de,
  input logic [DLANES-1:0] lane_d_o,
  input logic              lane_clk_o
);
  logic seen_load_q;
  logic de_sent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_load_q <= 1'b0;
      de_sent_q   <= 1'b0;
    end else if (in_ready) begin
      seen_load_q <= 1'b1;
      de_sent_q   <= in_valid & in_de;
    end
  end

  // R1
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  // R3
  clk_first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> lane_clk_o);

  // R3
  clk_last_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && seen_load_q) |-> lane_clk_o);

  // R7
  spare_lane_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_d_o[DLANES-1]);

  // R6
  de_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && seen_load_q) |-> (lane_d_o[SYNC_LANE] == de_sent_q));

  // R11
  quiet_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_load_q |-> (lane_d_o == '0 && !lane_clk_o));
endmodule

bind lvds_pix_serializer lvds_ser_chk #(.DLANES(DLANES), .SYNC_LANE(SYNC_LANE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_de(in_de), .lane_d_o(lane_d_o), .lane_clk_o(lane_clk_o)
);

// File: tb/tb_lvds_pix_serializer.sv
module tb_lvds_pix_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int CH_W   = 6;
  localparam int SLOTS  = 7;
  localparam int DLANES = 4;
  localparam int NBITS  = 3*CH_W + 3;

  logic clk, rst_n, in_valid, in_ready;
  logic [CH_W-1:0] in_red, in_grn, in_blu;
  logic in_hsync, in_vsync, in_de, cfg_map_sel, cfg_slot_swap;
  logic [DLANES-1:0] lane_d_o;
  logic lane_clk_o;

  int checks = 0, errors = 0;
  int phase_cnt = 0;
  bit last_hs = 0, last_vs = 0;
  bit [DLANES:0] exp_bits[$];
  int            exp_slot[$];

  lvds_pix_serializer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_red(in_red), .in_grn(in_grn), .in_blu(in_blu),
    .in_hsync(in_hsync), .in_vsync(in_vsync), .in_de(in_de),
    .cfg_map_sel(cfg_map_sel), .cfg_slot_swap(cfg_slot_swap),
    .lane_d_o(lane_d_o), .lane_clk_o(lane_clk_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // expected bits of one lane, indexed by slot (0 = slot 1), per R4/R5/R6/R8
  function automatic bit [SLOTS-1:0] lane_bits(int l, bit [CH_W-1:0] r, bit [CH_W-1:0] g,
      bit [CH_W-1:0] b, bit hs, bit vs, bit de, bit msb, bit sw);
    bit f[NBITS];
    bit [SLOTS-1:0] res;
    for (int i = 0; i < CH_W; i++) begin
      f[i]          = msb ? r[CH_W-1-i] : r[i];
      f[CH_W+i]     = msb ? g[CH_W-1-i] : g[i];
      f[2*CH_W+i]   = msb ? b[CH_W-1-i] : b[i];
    end
    f[NBITS-3] = hs; f[NBITS-2] = vs; f[NBITS-1] = de;
    for (int s = 0; s < SLOTS; s++) begin
      int src, idx;
      src = (sw && s < 6) ? (s ^ 1) : s;
      idx = l*SLOTS + src;
      res[s] = (idx < NBITS) ? f[idx] : 1'b0;
    end
    return res;
  endfunction

  task automatic report(string req, bit [DLANES:0] got, bit [DLANES:0] exp, int slot);
    errors++;
    $display("FAIL %s slot %0d: got clk/lanes %b expected %b", req, slot + 1, got, exp);
  endtask

  // one bit-clock cycle, called at a falling edge
  task automatic body(string tag, int vprob, bit cfg_churn);
    bit [DLANES:0] got, exp;
    int slot;
    bit er;
    got = {lane_clk_o, lane_d_o};
    if (exp_bits.size() > 0) begin
      exp = exp_bits.pop_front();
      slot = exp_slot.pop_front();
    end else begin
      exp = '0;   // R11: nothing loaded yet
      slot = -1;
    end
    // R2: one slot per cycle, slot 1 right after the load edge
    checks++;
    if (got !== exp) begin
      if (got[DLANES] !== exp[DLANES])           report("R3", got, exp, slot);
      else if (got[DLANES-1] !== exp[DLANES-1])  report("R7", got, exp, slot);
      else if (got[2] !== exp[2] && slot >= 4)   report("R6", got, exp, slot);
      else if (slot < 0)                          report("R11", got, exp, slot);
      else                                        report(tag, got, exp, slot);
    end
    // R1: strobe once in seven cycles
    er = (phase_cnt == 0);
    checks++;
    if (in_ready !== er) begin
      errors++;
      $display("FAIL R1: in_ready got %b expected %b", in_ready, er);
    end
    phase_cnt = (phase_cnt + 1) % SLOTS;

    in_valid = ($urandom % 100) < vprob;
    in_red = CH_W'($urandom); in_grn = CH_W'($urandom); in_blu = CH_W'($urandom);
    in_hsync = $urandom % 2; in_vsync = $urandom % 2; in_de = $urandom % 2;
    if (cfg_churn) begin   // R9: config moves between and at strobes
      cfg_map_sel = $urandom % 2;
      cfg_slot_swap = $urandom % 2;
    end

    if (er) begin
      bit [CH_W-1:0] r, g, b;
      bit hs, vs, de;
      bit [SLOTS-1:0] lw[DLANES];
      if (in_valid) begin
        r = in_red; g = in_grn; b = in_blu; hs = in_hsync; vs = in_vsync; de = in_de;
        last_hs = hs; last_vs = vs;
      end else begin   // R10: blank word
        r = '0; g = '0; b = '0; hs = last_hs; vs = last_vs; de = 1'b0;
      end
      for (int l = 0; l < DLANES; l++)
        lw[l] = lane_bits(l, r, g, b, hs, vs, de, cfg_map_sel, cfg_slot_swap);
      for (int s = 0; s < SLOTS; s++) begin
        bit [DLANES:0] e;
        e[DLANES] = (s < 2) || (s >= 5);   // R3 pattern 1100011
        for (int l = 0; l < DLANES; l++) e[l] = lw[l][s];
        exp_bits.push_back(e);
        exp_slot.push_back(s);
      end
    end
  endtask

  task automatic run(string tag, int words, int vprob, bit msb, bit sw, bit churn);
    cfg_map_sel = msb;
    cfg_slot_swap = sw;
    for (int i = 0; i < words*SLOTS; i++) begin
      @(negedge clk);
      body(tag, vprob, churn);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    in_red = '0; in_grn = '0; in_blu = '0;
    in_hsync = 1'b0; in_vsync = 1'b0; in_de = 1'b0;
    cfg_map_sel = 1'b0; cfg_slot_swap = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      checks++;   // R11: outputs quiet in reset
      if ({lane_clk_o, lane_d_o} !== '0) begin
        errors++;
        $display("FAIL R11: lanes in reset got %b expected 0", {lane_clk_o, lane_d_o});
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
    phase_cnt = 0;
    body("R11", 0, 1'b0);           // R11: strobe in the first cycle out of reset
    for (int i = 0; i < SLOTS-1; i++) begin
      @(negedge clk);
      body("R10", 0, 1'b0);
    end
    run("R4", 30, 100, 1'b0, 1'b0, 1'b0);
    run("R5", 30, 100, 1'b1, 1'b0, 1'b0);
    run("R8", 20, 100, 1'b0, 1'b1, 1'b0);
    run("R8", 20, 100, 1'b1, 1'b1, 1'b0);
    run("R10", 40, 40, 1'b0, 1'b0, 1'b0);
    run("R10", 30, 40, 1'b1, 1'b1, 1'b0);
    run("R9", 60, 80, 1'b0, 1'b0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule